// File: doc/BRIEF.md
# Translated Lookup with Physically Tagged Word Cache

This block turns a 32-bit virtual byte address into a physical one and then reads a word cache with the result. The virtual page number (the upper 20 bits) is compared in parallel against every entry of a small fully associative translation table. A matching entry supplies a 20-bit physical page number, which is joined to the untranslated 12-bit page offset. The physical address then selects one line of a direct-mapped cache and is compared against that line's stored tag.

The block resolves nothing by itself. A translation miss, a store to a page whose write-permission bit is clear, and a cache miss each raise a flag, and logic outside the block services the condition. That logic writes translations through an indexed load port and writes cache lines through a fill port. Every lookup is registered, so its result appears one clock after the request. The cache depth is a parameter: the full configuration has a 14-bit index, and the default build uses an 8-bit index so the bench can sweep every line.

Top module: `xlatCacheTop`

## Requirements
- R1: The virtual page number is `reqVaddr[31:12]` and the page offset is `reqVaddr[11:0]`. On a translation hit, `physAddr` equals `{ppn, reqVaddr[11:0]}`. On a translation miss, `physAddr` is 0.
- R2: The translation table has 64 entries, and each entry holds a valid bit, a write-permission (dirty) bit, a 20-bit virtual page tag and a 20-bit physical page number. One write through the load port replaces all four fields of the entry at `tlbWrIdx` in one cycle. A lookup in that same cycle sees the entry's previous contents.
- R3: When several valid entries match the virtual page number, the entry with the lowest index supplies the translation.
- R4: On a translation miss, `tlbMiss` is 1, and `cacheHit`, `cacheMiss` and `wrFault` are 0. `rdData` and `physAddr` are 0. An entry written with its valid bit at 0 never matches.
- R5: The cache index is `physAddr[IDX_W+1:2]` and the cache tag is `physAddr[31:IDX_W+2]`. With the full 14-bit index these are bits 15..2 and bits 31..16; with the default 8-bit index they are bits 9..2 and bits 31..10. A load hits only when the indexed line is valid and its tag is equal. On a hit, `rdData` is the stored word.
- R6: A load that translates but misses the cache raises `cacheMiss` and returns `rdData` equal to 0.
- R7: A store that hits a translation entry whose dirty bit is 0 raises `wrFault` and leaves the cache unchanged. It reports `cacheHit`, `cacheMiss` and `rdData` as 0, and `physAddr` still shows the translated address.
- R8: A store that hits a translation with the dirty bit at 1 behaves as follows. If the cache hits, it reports `cacheHit`, returns the old word on `rdData` and writes `reqWdata` into the line. If the cache misses, it raises `cacheMiss` and allocates nothing.
- R9: A fill writes the tag, the data and a set valid bit into the line that `fillLine` (physical address bits 31..2) selects. When a fill and a store target the same line in the same cycle, the line ends up holding the fill data.
- R10: A synchronous reset clears every valid bit in both tables and drives all response outputs to 0.
- R11: `rspValid` is high exactly one cycle after `reqValid`. While it is high, exactly one of `tlbMiss`, `wrFault`, `cacheHit` and `cacheMiss` is set. While it is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | A lookup is requested this cycle |
| reqWrite | input | 1 | The lookup is a store |
| reqVaddr | input | 32 | Virtual byte address |
| reqWdata | input | 32 | Store data |
| tlbWrEn | input | 1 | Write one translation entry |
| tlbWrIdx | input | 6 | Index of the entry to write |
| tlbWrValid | input | 1 | Valid bit to store |
| tlbWrDirty | input | 1 | Write-permission (dirty) bit to store |
| tlbWrVpn | input | 20 | Virtual page tag to store |
| tlbWrPpn | input | 20 | Physical page number to store |
| fillEn | input | 1 | Write one cache line |
| fillLine | input | 30 | Physical word address of the line (address bits 31..2) |
| fillData | input | 32 | Word written by the fill |
| rspValid | output | 1 | A response is present |
| tlbHit | output | 1 | The translation hit |
| tlbMiss | output | 1 | Fault: no valid translation |
| wrFault | output | 1 | Fault: store to a page without write permission |
| physAddr | output | 32 | Translated physical address |
| cacheHit | output | 1 | The cache hit |
| cacheMiss | output | 1 | The cache missed after a good translation |
| rdData | output | 32 | Word read from the cache |

## Verification
Two pairs of operations can meet in one cycle. The first pair is a translation-entry write and a lookup of the same page. The bench drives both in one cycle and expects the old physical page number, then repeats the lookup and expects the new page number together with a cache miss. The second pair is a fill and a permitted store that hits the same cache line. The bench expects the store response to report a hit with the old word, and a following load to return the fill data, not the store data.

// File: rtl/xlatPkg.sv
package xlatPkg;

  // Strobes that the control issues to the datapath for one cycle
  typedef struct packed {
    logic rspLoad;     // capture address/data for a response
    logic dataKeep;    // response carries the cache word
    logic storeWrite;  // write store data into the probed line
    logic fillWrite;   // write the fill port into its line
    logic tlbLoad;     // write one translation entry
  } xlatStrobe_t;

endpackage

// File: rtl/xlatPickLowest.sv
module xlatPickLowest #(
  parameter int N = 64,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grantIdx,
  output logic          any
);

  always_comb begin
    grantIdx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grantIdx = IW'(i);
    end
  end

  assign grant = req & ~(req - N'(1));
  assign any   = |req;

endmodule

// File: rtl/xlatCtrl.sv
module xlatCtrl
  import xlatPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        fillEn,
  input  logic        tlbWrEn,
  input  logic        tlbHitNow,
  input  logic        dirtyNow,
  input  logic        cacheHitNow,
  output xlatStrobe_t strb,
  output logic        rspValid,
  output logic        tlbHit,
  output logic        tlbMiss,
  output logic        wrFault,
  output logic        cacheHit,
  output logic        cacheMiss
);

  logic faultNow;
  logic goodNow;

  assign faultNow = reqWrite && tlbHitNow && !dirtyNow;
  assign goodNow  = tlbHitNow && !faultNow;

  always_comb begin
    strb.rspLoad    = reqValid;
    strb.dataKeep   = reqValid && goodNow && cacheHitNow;
    strb.storeWrite = reqValid && reqWrite && goodNow && cacheHitNow;
    strb.fillWrite  = fillEn;
    strb.tlbLoad    = tlbWrEn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rspValid  <= 1'b0;
      tlbHit    <= 1'b0;
      tlbMiss   <= 1'b0;
      wrFault   <= 1'b0;
      cacheHit  <= 1'b0;
      cacheMiss <= 1'b0;
    end else begin
      rspValid  <= reqValid;
      tlbHit    <= reqValid && tlbHitNow;
      tlbMiss   <= reqValid && !tlbHitNow;
      wrFault   <= reqValid && faultNow;
      cacheHit  <= reqValid && goodNow && cacheHitNow;
      cacheMiss <= reqValid && goodNow && !cacheHitNow;
    end
  end

  // R11: a request is answered on the next cycle
  a_r11_latency: assert property (@(posedge clk) disable iff (rst)
    reqValid |=> rspValid);

  // R11: one outcome per response
  a_r11_one_outcome: assert property (@(posedge clk) disable iff (rst)
    rspValid |-> ($countones({tlbMiss, wrFault, cacheHit, cacheMiss}) == 1));

  // R11: idle cycles show no flags
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !rspValid |-> !(tlbMiss || wrFault || cacheHit || cacheMiss || tlbHit));

  // R4: no cache hit without a translation
  a_r4_hit_needs_xlat: assert property (@(posedge clk) disable iff (rst)
    (cacheHit || cacheMiss || wrFault) |-> tlbHit);

endmodule

// File: rtl/xlatDatapath.sv
module xlatDatapath
  import xlatPkg::*;
#(
  parameter int PAGE_OFF_W = 12,
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 20,
  parameter int TLB_N      = 64,
  parameter int IDX_W      = 8,
  parameter int WORD_W     = 32,
  localparam int VA_W      = VPN_W + PAGE_OFF_W,
  localparam int PA_W      = PPN_W + PAGE_OFF_W,
  localparam int TLB_IW    = $clog2(TLB_N),
  localparam int TAG_W     = PA_W - IDX_W - 2,
  localparam int LINE_N    = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  xlatStrobe_t       strb,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic [TLB_IW-1:0] tlbWrIdx,
  input  logic              tlbWrValid,
  input  logic              tlbWrDirty,
  input  logic [VPN_W-1:0]  tlbWrVpn,
  input  logic [PPN_W-1:0]  tlbWrPpn,
  input  logic [PA_W-3:0]   fillLine,
  input  logic [WORD_W-1:0] fillData,
  output logic              tlbHitNow,
  output logic              dirtyNow,
  output logic              cacheHitNow,
  output logic [PA_W-1:0]   physAddr,
  output logic [WORD_W-1:0] rdData
);

  // translation table
  logic [TLB_N-1:0] tlbValid;
  logic [TLB_N-1:0] tlbDirty;
  logic [VPN_W-1:0] tlbVpn [TLB_N];
  logic [PPN_W-1:0] tlbPpn [TLB_N];

  // cache
  logic [LINE_N-1:0] lineValid;
  logic [TAG_W-1:0]  lineTag  [LINE_N];
  logic [WORD_W-1:0] lineData [LINE_N];

  // lookup path
  logic [VPN_W-1:0]  vpn;
  logic [TLB_N-1:0]  hitVec;
  logic [TLB_N-1:0]  grantVec;
  logic [TLB_IW-1:0] pickIdx;
  logic [PA_W-1:0]   paddrNow;
  logic [IDX_W-1:0]  probeIdx;
  logic [TAG_W-1:0]  probeTag;
  logic [IDX_W-1:0]  fillIdx;
  logic [TAG_W-1:0]  fillTag;

  assign vpn = reqVaddr[VA_W-1:PAGE_OFF_W];

  for (genvar g = 0; g < TLB_N; g++) begin : gMatch
    assign hitVec[g] = tlbValid[g] && (tlbVpn[g] == vpn);
  end

  xlatPickLowest #(.N(TLB_N)) uPick (
    .req      (hitVec),
    .grant    (grantVec),
    .grantIdx (pickIdx),
    .any      (tlbHitNow)
  );

  assign dirtyNow    = tlbDirty[pickIdx];
  assign paddrNow    = {tlbPpn[pickIdx], reqVaddr[PAGE_OFF_W-1:0]};
  assign probeIdx    = paddrNow[IDX_W+1:2];
  assign probeTag    = paddrNow[PA_W-1:IDX_W+2];
  assign cacheHitNow = tlbHitNow && lineValid[probeIdx] && (lineTag[probeIdx] == probeTag);

  assign fillIdx = fillLine[IDX_W-1:0];
  assign fillTag = fillLine[PA_W-3:IDX_W];

  // translation entry load: all fields in one cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      tlbValid <= '0;
      tlbDirty <= '0;
    end else if (strb.tlbLoad) begin
      tlbValid[tlbWrIdx] <= tlbWrValid;
      tlbDirty[tlbWrIdx] <= tlbWrDirty;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.tlbLoad && !rst) begin
      tlbVpn[tlbWrIdx] <= tlbWrVpn;
      tlbPpn[tlbWrIdx] <= tlbWrPpn;
    end
  end

  // cache valid bits
  always_ff @(posedge clk) begin
    if (rst) lineValid <= '0;
    else if (strb.fillWrite) lineValid[fillIdx] <= 1'b1;
  end

  // cache contents: a fill is applied after a store, so it wins a collision
  always_ff @(posedge clk) begin
    if (!rst) begin
      if (strb.storeWrite) lineData[probeIdx] <= reqWdata;
      if (strb.fillWrite) begin
        lineTag[fillIdx]  <= fillTag;
        lineData[fillIdx] <= fillData;
      end
    end
  end

  // registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      physAddr <= '0;
      rdData   <= '0;
    end else if (strb.rspLoad) begin
      physAddr <= tlbHitNow ? paddrNow : '0;
      rdData   <= strb.dataKeep ? lineData[probeIdx] : '0;
    end
  end

  // R3: at most one entry wins, and only a matching one
  a_r3_single_grant: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grantVec) && ((grantVec & ~hitVec) == '0) && ((|grantVec) == (|hitVec)));

  // R7: a store never writes the cache without permission
  a_r7_no_store_on_fault: assert property (@(posedge clk) disable iff (rst)
    strb.storeWrite |-> (tlbHitNow && dirtyNow && cacheHitNow));

  // R9: a filled line is valid afterwards
  a_r9_fill_sets_valid: assert property (@(posedge clk) disable iff (rst)
    strb.fillWrite |=> lineValid[$past(fillIdx)]);

  // R10: reset leaves both tables empty
  a_r10_tables_cleared: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (lineValid == '0 && tlbValid == '0));

endmodule

// File: rtl/xlatCacheTop.sv
module xlatCacheTop
  import xlatPkg::*;
#(
  parameter int PAGE_OFF_W = 12,
  parameter int VPN_W      = 20,
  parameter int PPN_W      = 20,
  parameter int TLB_N      = 64,
  parameter int IDX_W      = 8,
  parameter int WORD_W     = 32,
  localparam int VA_W      = VPN_W + PAGE_OFF_W,
  localparam int PA_W      = PPN_W + PAGE_OFF_W,
  localparam int TLB_IW    = $clog2(TLB_N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [VA_W-1:0]   reqVaddr,
  input  logic [WORD_W-1:0] reqWdata,
  input  logic              tlbWrEn,
  input  logic [TLB_IW-1:0] tlbWrIdx,
  input  logic              tlbWrValid,
  input  logic              tlbWrDirty,
  input  logic [VPN_W-1:0]  tlbWrVpn,
  input  logic [PPN_W-1:0]  tlbWrPpn,
  input  logic              fillEn,
  input  logic [PA_W-3:0]   fillLine,
  input  logic [WORD_W-1:0] fillData,
  output logic              rspValid,
  output logic              tlbHit,
  output logic              tlbMiss,
  output logic              wrFault,
  output logic [PA_W-1:0]   physAddr,
  output logic              cacheHit,
  output logic              cacheMiss,
  output logic [WORD_W-1:0] rdData
);

  xlatStrobe_t strb;
  logic        tlbHitNow;
  logic        dirtyNow;
  logic        cacheHitNow;

  xlatCtrl uCtrl (
    .clk         (clk),
    .rst         (rst),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .fillEn      (fillEn),
    .tlbWrEn     (tlbWrEn),
    .tlbHitNow   (tlbHitNow),
    .dirtyNow    (dirtyNow),
    .cacheHitNow (cacheHitNow),
    .strb        (strb),
    .rspValid    (rspValid),
    .tlbHit      (tlbHit),
    .tlbMiss     (tlbMiss),
    .wrFault     (wrFault),
    .cacheHit    (cacheHit),
    .cacheMiss   (cacheMiss)
  );

  xlatDatapath #(
    .PAGE_OFF_W (PAGE_OFF_W),
    .VPN_W      (VPN_W),
    .PPN_W      (PPN_W),
    .TLB_N      (TLB_N),
    .IDX_W      (IDX_W),
    .WORD_W     (WORD_W)
  ) uData (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .reqVaddr    (reqVaddr),
    .reqWdata    (reqWdata),
    .tlbWrIdx    (tlbWrIdx),
    .tlbWrValid  (tlbWrValid),
    .tlbWrDirty  (tlbWrDirty),
    .tlbWrVpn    (tlbWrVpn),
    .tlbWrPpn    (tlbWrPpn),
    .fillLine    (fillLine),
    .fillData    (fillData),
    .tlbHitNow   (tlbHitNow),
    .dirtyNow    (dirtyNow),
    .cacheHitNow (cacheHitNow),
    .physAddr    (physAddr),
    .rdData      (rdData)
  );

endmodule

// File: tb/sim_xlatCacheTop.sv
module sim_xlatCacheTop;

  localparam int IDX_W  = 8;
  localparam int LINES  = 1 << IDX_W;
  localparam int TAG_W  = 32 - IDX_W - 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [31:0] reqVaddr = '0, reqWdata = '0;
  logic        tlbWrEn = 1'b0, tlbWrValid = 1'b0, tlbWrDirty = 1'b0;
  logic [5:0]  tlbWrIdx = '0;
  logic [19:0] tlbWrVpn = '0, tlbWrPpn = '0;
  logic        fillEn = 1'b0;
  logic [29:0] fillLine = '0;
  logic [31:0] fillData = '0;
  logic        rspValid, tlbHit, tlbMiss, wrFault, cacheHit, cacheMiss;
  logic [31:0] physAddr, rdData;

  xlatCacheTop #(.IDX_W(IDX_W)) u0 (
    .clk(clk), .rst(rst), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqVaddr(reqVaddr), .reqWdata(reqWdata), .tlbWrEn(tlbWrEn),
    .tlbWrIdx(tlbWrIdx), .tlbWrValid(tlbWrValid), .tlbWrDirty(tlbWrDirty),
    .tlbWrVpn(tlbWrVpn), .tlbWrPpn(tlbWrPpn), .fillEn(fillEn),
    .fillLine(fillLine), .fillData(fillData), .rspValid(rspValid),
    .tlbHit(tlbHit), .tlbMiss(tlbMiss), .wrFault(wrFault),
    .physAddr(physAddr), .cacheHit(cacheHit), .cacheMiss(cacheMiss),
    .rdData(rdData)
  );

  always #10 clk = ~clk;  // 50 MHz

  int nChecks = 0;
  int nFail   = 0;
  int cycles  = 0;
  bit done    = 1'b0;

  // reference model
  bit          mVal [64];
  bit          mDirty [64];
  logic [19:0] mVpn [64];
  logic [19:0] mPpn [64];
  bit          cV [LINES];
  logic [TAG_W-1:0] cT [LINES];
  logic [31:0] cD [LINES];

  function automatic logic [19:0] vpnOf(int i);
    return 20'h00100 + 20'(i);
  endfunction
  function automatic logic [19:0] ppnOf(int i);
    return 20'h80000 | 20'(i * 311);
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic clearModel();
    for (int i = 0; i < 64; i++) mVal[i] = 1'b0;
    for (int k = 0; k < LINES; k++) cV[k] = 1'b0;
  endtask

  // drives a table load; commit applies it to the model
  task automatic driveTlb(int idx, bit v, bit d, logic [19:0] vp, logic [19:0] pp);
    tlbWrEn = 1'b1; tlbWrIdx = 6'(idx); tlbWrValid = v; tlbWrDirty = d;
    tlbWrVpn = vp; tlbWrPpn = pp;
  endtask
  task automatic commitTlb();
    mVal[tlbWrIdx] = tlbWrValid; mDirty[tlbWrIdx] = tlbWrDirty;
    mVpn[tlbWrIdx] = tlbWrVpn;   mPpn[tlbWrIdx] = tlbWrPpn;
  endtask
  task automatic loadTlb(int idx, bit v, bit d, logic [19:0] vp, logic [19:0] pp);
    driveTlb(idx, v, d, vp, pp);
    @(negedge clk);
    commitTlb();
    tlbWrEn = 1'b0;
  endtask

  task automatic driveFill(logic [31:0] pa, logic [31:0] data);
    fillEn = 1'b1; fillLine = pa[31:2]; fillData = data;
  endtask
  task automatic commitFill();
    cV[fillLine[IDX_W-1:0]] = 1'b1;
    cT[fillLine[IDX_W-1:0]] = fillLine[29:IDX_W];
    cD[fillLine[IDX_W-1:0]] = fillData;
  endtask
  task automatic fill(logic [31:0] pa, logic [31:0] data);
    driveFill(pa, data);
    @(negedge clk);
    commitFill();
    fillEn = 1'b0;
  endtask

  // one request; concurrent table/fill writes are committed by the caller
  task automatic doReq(bit wr, logic [31:0] va, logic [31:0] wd, string req);
    bit hit, fault, ch, cm;
    int sel;
    logic [31:0] pa, eData;
    logic [IDX_W-1:0] ix;
    reqValid = 1'b1; reqWrite = wr; reqVaddr = va; reqWdata = wd;
    hit = 1'b0; sel = 0;
    for (int i = 0; i < 64; i++)
      if (!hit && mVal[i] && mVpn[i] == va[31:12]) begin hit = 1'b1; sel = i; end
    pa    = hit ? {mPpn[sel], va[11:0]} : 32'h0;
    ix    = pa[IDX_W+1:2];
    fault = wr && hit && !mDirty[sel];
    ch    = hit && !fault && cV[ix] && (cT[ix] == pa[31:IDX_W+2]);
    cm    = hit && !fault && !ch;
    eData = ch ? cD[ix] : 32'h0;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, "flags {rsp,tlbHit,tlbMiss,wrFault,cacheHit,cacheMiss}",
          64'({rspValid, tlbHit, tlbMiss, wrFault, cacheHit, cacheMiss}),
          64'({1'b1, hit, !hit, fault, ch, cm}));
    check(req, "physAddr", 64'(physAddr), 64'(pa));
    check(req, "rdData", 64'(rdData), 64'(eData));
    if (wr && ch) cD[ix] = wd;
    tlbWrEn = 1'b0;
    fillEn  = 1'b0;
  endtask

  initial begin
    clearModel();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    check("R10", "outputs after reset",
          64'({rspValid, tlbHit, tlbMiss, wrFault, cacheHit, cacheMiss, physAddr, rdData}), 64'h0);
    @(negedge clk);
    check("R11", "idle flags", 64'({rspValid, tlbMiss, wrFault, cacheHit, cacheMiss}), 64'h0);
    doReq(1'b0, 32'h0010_0000, 32'h0, "R4");

    // R2: load every entry, odd entries writable
    for (int i = 0; i < 64; i++) loadTlb(i, 1'b1, i[0], vpnOf(i), ppnOf(i));
    // R9: fill every line; line k belongs to the page of entry k%64
    for (int k = 0; k < LINES; k++)
      fill({ppnOf(k % 64), 12'(k * 4)}, 32'hA500_0000 ^ (32'(k) * 32'h0001_0203));

    // R1 R5 R6: sweep loads through every entry
    for (int i = 0; i < 64; i++) begin
      for (int q = 0; q < LINES / 64; q++)
        doReq(1'b0, {vpnOf(i), 12'((i + 64 * q) * 4)}, 32'h0, "R5");
      doReq(1'b0, {vpnOf(i), 12'(12'h400 + i * 4)}, 32'h0, "R6");
    end
    // R4: unmapped pages
    doReq(1'b0, 32'hFFFF_F004, 32'h0, "R4");
    doReq(1'b1, 32'h0000_0000, 32'h1234, "R4");

    // R7 R8: stores, then read back
    for (int i = 0; i < 64; i++) begin
      doReq(1'b1, {vpnOf(i), 12'(i * 4)}, ~32'(i), i[0] ? "R8" : "R7");
      doReq(1'b0, {vpnOf(i), 12'(i * 4)}, 32'h0, i[0] ? "R8" : "R7");
      doReq(1'b1, {vpnOf(i), 12'(12'h800 + i * 4)}, 32'h5555_0000, i[0] ? "R8" : "R7");
      doReq(1'b0, {vpnOf(i), 12'(12'h800 + i * 4)}, 32'h0, "R8");
    end

    // R9: fill and store to the same line in one cycle
    driveFill({ppnOf(1), 12'h004}, 32'hFEED_F00D);
    doReq(1'b1, {vpnOf(1), 12'h004}, 32'h1111_2222, "R9");
    commitFill();
    doReq(1'b0, {vpnOf(1), 12'h004}, 32'h0, "R9");

    // R2: table write and lookup of the same page in one cycle
    driveTlb(3, 1'b1, 1'b1, vpnOf(3), 20'h7ABCD);
    doReq(1'b0, {vpnOf(3), 12'h00C}, 32'h0, "R2");
    commitTlb();
    doReq(1'b0, {vpnOf(3), 12'h00C}, 32'h0, "R2");

    // R3: duplicate tags, lowest index wins
    loadTlb(40, 1'b1, 1'b1, vpnOf(9), 20'h12345);
    doReq(1'b0, {vpnOf(9), 12'h024}, 32'h0, "R3");
    loadTlb(5, 1'b1, 1'b1, vpnOf(9), 20'h54321);
    doReq(1'b0, {vpnOf(9), 12'h024}, 32'h0, "R3");
    check("R3", "physAddr from entry 5", 64'(physAddr), 64'h5432_1024);

    // R4: an entry written invalid never matches
    loadTlb(20, 1'b0, 1'b1, vpnOf(20), ppnOf(20));
    doReq(1'b0, {vpnOf(20), 12'h050}, 32'h0, "R4");

    // R10: reset mid-run empties both tables
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    clearModel();
    check("R10", "outputs after second reset",
          64'({rspValid, tlbHit, tlbMiss, cacheHit, physAddr, rdData}), 64'h0);
    doReq(1'b0, {vpnOf(0), 12'h000}, 32'h0, "R10");
    loadTlb(0, 1'b1, 1'b1, vpnOf(0), ppnOf(0));
    doReq(1'b0, {vpnOf(0), 12'h000}, 32'h0, "R10");
    check("R10", "cache empty after reset", 64'(cacheMiss), 64'h1);

    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule